// File: doc/BRIEF.md
# SDRAM Bank Row Scheduler

This block sits between a request decoder and an SDRAM transfer engine. It receives requests that already carry a bank, a row and a column, and keeps a record for each bank of whether a row is open and which one. For each request at the head of its queue it works out whether the open row matches. A match goes straight to a read or write. A mismatch first closes the bank and then opens the wanted row. A closed bank only needs the open step.

Each command goes to the transfer engine on a valid/acknowledge pair and is held until accepted. Per-bank counters enforce the row-active, precharge-recovery and activate-to-access delays. These delays are set by run-time inputs. The transfer engine reports, per bank, whether a close is currently allowed, and globally whether an open is allowed. A small in-order queue holds requests to distinct banks. A configuration input limits how many entries it accepts. A request flagged as the last of a stream closes its bank once its transfer is accepted. A refresh pulse from downstream marks every bank closed.

Top module: `row_bank_ctrl`

## Requirements
- R1: While rst_ni is low and right after it is released, cmd_vld_o is 0 and idle_o is 1. A request offered to the empty queue is accepted (req_ack_o is 1).
- R2: A request to a closed bank produces first an activate, with cmd_o = 2'b01 and cmd_addr_o = row. It then produces a read (2'b10) or a write (2'b11), with cmd_addr_o = column and cmd_bank_o = the request bank.
- R3: A request whose row equals the open row of its bank produces only the read or write command.
- R4: A request to a bank with a different open row produces a precharge (cmd_o = 2'b00), then an activate of the new row, then the transfer.
- R5: A read or write that follows an activate of its bank is first presented no sooner than t_rcd_i+1 clock edges after the edge that accepted the activate.
- R6: An activate that follows a precharge of its bank is first presented no sooner than t_rp_i+1 edges after the edge that accepted the precharge.
- R7: A precharge is first presented no sooner than t_ras_i+1 edges after the edge that accepted the last activate of that bank.
- R8: A precharge of bank b is loaded only while pre_ok_i[b] is 1, and an activate is loaded only while act_ok_i is 1. While these are 0, no such command appears.
- R9: While cmd_vld_o is 1 and cmd_ack_i is 0, cmd_vld_o, cmd_o, cmd_bank_o and cmd_addr_o stay unchanged on the next edge.
- R10: A request with req_close_i = 1 is followed, after its transfer is accepted, by a precharge of its bank.
- R11: A one-cycle pulse on refresh_i marks every bank closed. A later request to the previously open row produces an activate again.
- R12: A request is accepted only if the queue holds fewer than depth_cfg_i+1 entries and no queued entry targets the same bank. Requests are served in acceptance order.
- R13: idle_o is 1 only when the queue is empty and no command is pending. It is 0 on the cycle after any acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| depth_cfg_i | input | 2 | Queue limit minus one |
| t_ras_i | input | 4 | Activate-to-precharge delay in cycles |
| t_rp_i | input | 4 | Precharge-to-activate delay in cycles |
| t_rcd_i | input | 4 | Activate-to-access delay in cycles |
| req_i | input | 1 | Request valid |
| req_bank_i | input | 2 | Request bank |
| req_row_i | input | 12 | Request row |
| req_col_i | input | 12 | Request column |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_close_i | input | 1 | Close the bank after this transfer |
| req_ack_o | output | 1 | Request accepted this cycle |
| pre_ok_i | input | 4 | Per-bank precharge permission |
| act_ok_i | input | 1 | Activate permission |
| refresh_i | input | 1 | Refresh pulse; all banks closed |
| cmd_vld_o | output | 1 | Command valid |
| cmd_o | output | 2 | Command code (00 pre, 01 act, 10 read, 11 write) |
| cmd_bank_o | output | 2 | Command bank |
| cmd_addr_o | output | 12 | Row for activate, column for access |
| cmd_ack_i | input | 1 | Command accepted |
| idle_o | output | 1 | No queued request and no pending command |

## Verification
A corrupted open-row record shows up at the ports on the next command for that bank. A stale hit appears as a bare read or write where a precharge/activate pair was due. A lost record appears as a redundant activate. Both are visible within a few cycles of the request reaching the head of the queue. A wrong timing counter shows as a gap that is too short between an accepted command and the next valid one on the same bank. The bench measures this gap against each configured delay. Queue faults appear immediately on req_ack_o, or as commands issued out of acceptance order.

// File: rtl/row_bank_pkg.sv
package row_bank_pkg;
  localparam int BANK_W = 2;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    CMD_PRE = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } bank_cmd_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] row;
    logic [ADDR_W-1:0] col;
    logic              write;
    logic              close;
  } bank_req_t;
endpackage

// File: rtl/rb_req_queue.sv
module rb_req_queue
  import row_bank_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NB = 1 << BANK_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  bank_req_t       push_data_i,
  input  logic            pop_i,
  output bank_req_t       head_o,
  output logic            head_vld_o,
  output logic [CNT_W-1:0] count_o,
  output logic [NB-1:0]   bank_busy_o
);
  bank_req_t  slot_q    [DEPTH];
  logic       vld_q     [DEPTH];
  bank_req_t  shift_data[DEPTH];
  logic       shift_vld [DEPTH];
  logic [CNT_W-1:0] wr_idx;

  always_comb begin
    count_o     = '0;
    bank_busy_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      count_o = count_o + {{(CNT_W-1){1'b0}}, vld_q[i]};
      if (vld_q[i]) bank_busy_o[slot_q[i].bank] = 1'b1;
    end
  end

  assign wr_idx     = count_o - {{(CNT_W-1){1'b0}}, pop_i};
  assign head_o     = slot_q[0];
  assign head_vld_o = vld_q[0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g < DEPTH - 1) begin : g_mid
      assign shift_data[g] = slot_q[g+1];
      assign shift_vld[g]  = vld_q[g+1];
    end else begin : g_end
      assign shift_data[g] = slot_q[g];
      assign shift_vld[g]  = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else begin
        if (pop_i) begin
          slot_q[g] <= shift_data[g];
          vld_q[g]  <= shift_vld[g];
        end
        if (push_i && wr_idx == CNT_W'(g)) begin
          slot_q[g] <= push_data_i;
          vld_q[g]  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rb_bank_state.sv
module rb_bank_state
  import row_bank_pkg::*;
#(
  parameter int TIME_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              pre_i,
  input  logic              wipe_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [TIME_W-1:0] t_ras_i,
  input  logic [TIME_W-1:0] t_rp_i,
  input  logic [TIME_W-1:0] t_rcd_i,
  output logic              open_o,
  output logic [ADDR_W-1:0] row_o,
  output logic              ras_ok_o,
  output logic              rp_ok_o,
  output logic              rcd_ok_o
);
  logic [TIME_W-1:0] ras_q, rp_q, rcd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
      ras_q  <= '0;
      rp_q   <= '0;
      rcd_q  <= '0;
    end else begin
      if (ras_q != '0) ras_q <= ras_q - 1'b1;
      if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (act_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
        ras_q  <= t_ras_i;
        rcd_q  <= t_rcd_i;
      end
      if (pre_i) begin
        open_o <= 1'b0;
        rp_q   <= t_rp_i;
      end
      if (wipe_i) open_o <= 1'b0;
    end
  end

  assign ras_ok_o = (ras_q == '0);
  assign rp_ok_o  = (rp_q  == '0);
  assign rcd_ok_o = (rcd_q == '0);
endmodule

// File: rtl/row_bank_ctrl.sv
module row_bank_ctrl
  import row_bank_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4,
  parameter int TIME_W = 4,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int DEPTH_W = $clog2(QUEUE_DEPTH),
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DEPTH_W-1:0]   depth_cfg_i,
  input  logic [TIME_W-1:0]    t_ras_i,
  input  logic [TIME_W-1:0]    t_rp_i,
  input  logic [TIME_W-1:0]    t_rcd_i,
  input  logic                 req_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [ADDR_W-1:0]    req_row_i,
  input  logic [ADDR_W-1:0]    req_col_i,
  input  logic                 req_write_i,
  input  logic                 req_close_i,
  output logic                 req_ack_o,
  input  logic [NUM_BANKS-1:0] pre_ok_i,
  input  logic                 act_ok_i,
  input  logic                 refresh_i,
  output logic                 cmd_vld_o,
  output logic [1:0]           cmd_o,
  output logic [BANK_W-1:0]    cmd_bank_o,
  output logic [ADDR_W-1:0]    cmd_addr_o,
  input  logic                 cmd_ack_i,
  output logic                 idle_o
);
  bank_req_t            head, push_data;
  logic                 head_vld, pop, drop, fire, done_q;
  logic [CNT_W-1:0]     count, limit;
  logic [NUM_BANKS-1:0] busy;
  logic                 b_open [NUM_BANKS];
  logic [ADDR_W-1:0]    b_row  [NUM_BANKS];
  logic                 b_ras_ok [NUM_BANKS];
  logic                 b_rp_ok  [NUM_BANKS];
  logic                 b_rcd_ok [NUM_BANKS];

  bank_cmd_e            cmd_q, cand_cmd;
  logic                 cmd_vld_q, cand_vld;
  logic [BANK_W-1:0]    cmd_bank_q;
  logic [ADDR_W-1:0]    cmd_addr_q, cand_addr;
  logic [BANK_W-1:0]    hb;

  assign limit     = CNT_W'(depth_cfg_i) + CNT_W'(1);
  assign req_ack_o = req_i && (count < limit) && !busy[req_bank_i];
  assign push_data = '{bank: req_bank_i, row: req_row_i, col: req_col_i,
                       write: req_write_i, close: req_close_i};

  rb_req_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i(req_ack_o), .push_data_i(push_data), .pop_i(pop),
    .head_o(head), .head_vld_o(head_vld), .count_o(count), .bank_busy_o(busy)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    rb_bank_state #(.TIME_W(TIME_W)) u_state (
      .clk_i, .rst_ni,
      .act_i (fire && cmd_q == CMD_ACT && cmd_bank_q == BANK_W'(g)),
      .pre_i (fire && cmd_q == CMD_PRE && cmd_bank_q == BANK_W'(g)),
      .wipe_i(refresh_i),
      .row_i (cmd_addr_q),
      .t_ras_i, .t_rp_i, .t_rcd_i,
      .open_o(b_open[g]), .row_o(b_row[g]),
      .ras_ok_o(b_ras_ok[g]), .rp_ok_o(b_rp_ok[g]), .rcd_ok_o(b_rcd_ok[g])
    );
  end

  assign hb = head.bank;

  // next command for the head entry, only while the command slot is free
  always_comb begin
    cand_vld  = 1'b0;
    cand_cmd  = CMD_PRE;
    cand_addr = '0;
    drop      = 1'b0;
    if (head_vld && !cmd_vld_q) begin
      if (done_q) begin
        if (!b_open[hb]) drop = 1'b1;
        else if (b_ras_ok[hb] && pre_ok_i[hb]) cand_vld = 1'b1;
      end else if (b_open[hb] && b_row[hb] == head.row) begin
        if (b_rcd_ok[hb]) begin
          cand_vld  = 1'b1;
          cand_cmd  = head.write ? CMD_WR : CMD_RD;
          cand_addr = head.col;
        end
      end else if (b_open[hb]) begin
        if (b_ras_ok[hb] && pre_ok_i[hb]) cand_vld = 1'b1;
      end else if (b_rp_ok[hb] && act_ok_i) begin
        cand_vld  = 1'b1;
        cand_cmd  = CMD_ACT;
        cand_addr = head.row;
      end
    end
  end

  assign fire = cmd_vld_q && cmd_ack_i;
  assign pop  = drop || (fire && (cmd_q == CMD_PRE ? done_q
                                  : (cmd_q != CMD_ACT && !head.close)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_q  <= 1'b0;
      cmd_q      <= CMD_PRE;
      cmd_bank_q <= '0;
      cmd_addr_q <= '0;
      done_q     <= 1'b0;
    end else begin
      if (fire) cmd_vld_q <= 1'b0;
      else if (cand_vld) begin
        cmd_vld_q  <= 1'b1;
        cmd_q      <= cand_cmd;
        cmd_bank_q <= hb;
        cmd_addr_q <= cand_addr;
      end
      if (pop) done_q <= 1'b0;
      else if (fire && (cmd_q == CMD_RD || cmd_q == CMD_WR) && head.close) done_q <= 1'b1;
    end
  end

  assign cmd_vld_o  = cmd_vld_q;
  assign cmd_o      = cmd_q;
  assign cmd_bank_o = cmd_bank_q;
  assign cmd_addr_o = cmd_addr_q;
  assign idle_o     = !head_vld && !cmd_vld_q;
endmodule

// File: rtl/row_bank_ctrl_chk.sv
module row_bank_ctrl_chk
  import row_bank_pkg::*;
#(
  parameter int NUM_BANKS = 1 << BANK_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 req_ack_o,
  input logic [NUM_BANKS-1:0] pre_ok_i,
  input logic                 act_ok_i,
  input logic                 cmd_vld_o,
  input logic [1:0]           cmd_o,
  input logic [BANK_W-1:0]    cmd_bank_o,
  input logic [ADDR_W-1:0]    cmd_addr_o,
  input logic                 cmd_ack_i,
  input logic                 idle_o
);
  logic [NUM_BANKS-1:0] pre_ok_q;
  logic                 act_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_ok_q <= '0;
      act_ok_q <= 1'b0;
    end else begin
      pre_ok_q <= pre_ok_i;
      act_ok_q <= act_ok_i;
    end
  end

  // R9
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && !cmd_ack_i) |=> (cmd_vld_o && $stable(cmd_o) &&
                                   $stable(cmd_bank_o) && $stable(cmd_addr_o)));

  // R12
  ack_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |-> req_i);

  // R13
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |=> !idle_o);

  // R8
  pre_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cmd_vld_o) && cmd_o == 2'b00) |-> pre_ok_q[cmd_bank_o]);

  // R8
  act_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cmd_vld_o) && cmd_o == 2'b01) |-> act_ok_q);
endmodule

bind row_bank_ctrl row_bank_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_ack_o(req_ack_o),
  .pre_ok_i(pre_ok_i), .act_ok_i(act_ok_i), .cmd_vld_o(cmd_vld_o),
  .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o),
  .cmd_ack_i(cmd_ack_i), .idle_o(idle_o)
);

// File: tb/sim_row_bank_ctrl.sv
module sim_row_bank_ctrl;
  localparam int TRAS = 12, TRP = 3, TRCD = 2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  depth_cfg_i = 2'd3;
  logic [3:0]  t_ras_i = 4'(TRAS), t_rp_i = 4'(TRP), t_rcd_i = 4'(TRCD);
  logic        req_i = 1'b0, req_write_i = 1'b0, req_close_i = 1'b0;
  logic [1:0]  req_bank_i = '0;
  logic [11:0] req_row_i = '0, req_col_i = '0;
  logic        req_ack_o;
  logic [3:0]  pre_ok_i = 4'hF;
  logic        act_ok_i = 1'b1, refresh_i = 1'b0;
  logic        cmd_vld_o, cmd_ack_i = 1'b0, idle_o;
  logic [1:0]  cmd_o, cmd_bank_o;
  logic [11:0] cmd_addr_o;

  int checks = 0, errors = 0, cyc = 0;
  int lg_cmd[256], lg_bank[256], lg_addr[256], lg_cyc[256];
  int lg_n = 0;
  bit hold = 1'b0;

  always #2 clk_i = ~clk_i;

  row_bank_ctrl u0 (.*);

  always @(posedge clk_i) cyc++;

  // transfer engine model: accepts at first sight unless held
  always @(negedge clk_i) begin
    if (cmd_vld_o && !hold) begin
      cmd_ack_i = 1'b1;
      if (lg_n < 256) begin
        lg_cmd[lg_n] = int'(cmd_o); lg_bank[lg_n] = int'(cmd_bank_o);
        lg_addr[lg_n] = int'(cmd_addr_o); lg_cyc[lg_n] = cyc;
        lg_n++;
      end
    end else cmd_ack_i = 1'b0;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_cmd(int i, int c, int b, int a, string req);
    chk(lg_cmd[i] == c, req, "command code", lg_cmd[i], c);
    chk(lg_bank[i] == b, req, "command bank", lg_bank[i], b);
    chk(lg_addr[i] == a, req, "command addr", lg_addr[i], a);
  endtask

  task automatic chk_gap(int i, int n, string req);
    chk(lg_cyc[i] - lg_cyc[i-1] >= n + 2, req, "command spacing",
        lg_cyc[i] - lg_cyc[i-1], n + 2);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic drive(int b, int row, int col, bit wr, bit cl);
    req_bank_i = 2'(b); req_row_i = 12'(row); req_col_i = 12'(col);
    req_write_i = wr; req_close_i = cl; req_i = 1'b1;
  endtask

  task automatic send(int b, int row, int col, bit wr, bit cl);
    int n = 0;
    @(negedge clk_i);
    drive(b, row, col, wr, cl);
    #1;
    while (!req_ack_o && n < 200) begin @(negedge clk_i); #1; n++; end
    if (n >= 200) chk(1'b0, "R12", "request never accepted", 0, 1);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic try_req(int b, output bit acc);
    @(negedge clk_i);
    drive(b, b + 1, b + 8, 1'b0, 1'b0);
    #1;
    acc = req_ack_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    @(negedge clk_i);
    while (!idle_o && n < 500) begin @(negedge clk_i); n++; end
    chk(idle_o == 1'b1, req, "returns to idle", int'(idle_o), 1);
  endtask

  task automatic t_reset();
    bit acc;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(cmd_vld_o == 1'b0, "R1", "no command in reset", int'(cmd_vld_o), 0);
    chk(idle_o == 1'b1, "R1", "idle in reset", int'(idle_o), 1);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(idle_o == 1'b1, "R1", "idle after reset", int'(idle_o), 1);
    hold = 1'b1;
    try_req(0, acc);
    chk(acc, "R1", "empty queue accepts", int'(acc), 1);
    do_reset();
    hold = 1'b0;
  endtask

  task automatic t_closed_and_hit();
    int base;
    do_reset();
    base = lg_n;
    send(1, 'h12, 'h34, 1'b0, 1'b0);
    wait_idle("R2");
    chk(lg_n - base == 2, "R2", "command count", lg_n - base, 2);
    chk_cmd(base, 1, 1, 'h12, "R2");
    chk_cmd(base + 1, 2, 1, 'h34, "R2");
    chk_gap(base + 1, TRCD, "R5");
    base = lg_n;
    send(1, 'h12, 'h40, 1'b1, 1'b0);
    wait_idle("R3");
    chk(lg_n - base == 1, "R3", "hit command count", lg_n - base, 1);
    chk_cmd(base, 3, 1, 'h40, "R3");
  endtask

  task automatic t_miss();
    int base;
    do_reset();
    base = lg_n;
    send(0, 'h21, 'h05, 1'b0, 1'b0);
    wait_idle("R4");
    send(0, 'h33, 'h06, 1'b1, 1'b0);
    wait_idle("R4");
    chk(lg_n - base == 5, "R4", "command count", lg_n - base, 5);
    chk_cmd(base + 2, 0, 0, int'(lg_addr[base + 2]), "R4");
    chk_cmd(base + 3, 1, 0, 'h33, "R4");
    chk_cmd(base + 4, 3, 0, 'h06, "R4");
    chk(lg_cyc[base + 2] - lg_cyc[base] >= TRAS + 2, "R7", "activate to precharge",
        lg_cyc[base + 2] - lg_cyc[base], TRAS + 2);
    chk_gap(base + 3, TRP, "R6");
    chk_gap(base + 4, TRCD, "R5");
  endtask

  task automatic t_close_hint();
    int base;
    do_reset();
    base = lg_n;
    send(2, 7, 8, 1'b0, 1'b1);
    wait_idle("R10");
    chk(lg_n - base == 3, "R10", "command count", lg_n - base, 3);
    chk_cmd(base + 1, 2, 2, 8, "R10");
    chk_cmd(base + 2, 0, 2, int'(lg_addr[base + 2]), "R10");
  endtask

  task automatic t_refresh();
    int base;
    do_reset();
    send(3, 7, 9, 1'b0, 1'b0);
    wait_idle("R11");
    @(negedge clk_i); refresh_i = 1'b1;
    @(negedge clk_i); refresh_i = 1'b0;
    base = lg_n;
    send(3, 7, 10, 1'b0, 1'b0);
    wait_idle("R11");
    chk(lg_n - base == 2, "R11", "command count after refresh", lg_n - base, 2);
    chk_cmd(base, 1, 3, 7, "R11");
    chk_cmd(base + 1, 2, 3, 10, "R11");
  endtask

  task automatic t_gate();
    int base;
    do_reset();
    pre_ok_i = 4'hE;
    send(0, 1, 1, 1'b0, 1'b0);
    wait_idle("R8");
    base = lg_n;
    send(0, 2, 2, 1'b0, 1'b0);
    repeat (30) @(negedge clk_i);
    chk(lg_n - base == 0, "R8", "no precharge while blocked", lg_n - base, 0);
    chk(idle_o == 1'b0, "R8", "still busy while blocked", int'(idle_o), 0);
    pre_ok_i = 4'hF;
    wait_idle("R8");
    chk_cmd(base, 0, 0, int'(lg_addr[base]), "R8");
    act_ok_i = 1'b0;
    base = lg_n;
    send(1, 4, 4, 1'b0, 1'b0);
    repeat (30) @(negedge clk_i);
    chk(lg_n - base == 0, "R8", "no activate while blocked", lg_n - base, 0);
    act_ok_i = 1'b1;
    wait_idle("R8");
    chk_cmd(base, 1, 1, 4, "R8");
  endtask

  task automatic t_hold();
    do_reset();
    hold = 1'b1;
    send(1, 5, 6, 1'b0, 1'b0);
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < 5; i++) begin
      chk(cmd_vld_o == 1'b1, "R9", "held valid", int'(cmd_vld_o), 1);
      chk(cmd_o == 2'b01 && cmd_addr_o == 12'd5, "R9", "held activate row",
          int'(cmd_addr_o), 5);
      @(negedge clk_i);
    end
    hold = 1'b0;
    wait_idle("R9");
  endtask

  task automatic t_queue();
    int base;
    bit acc;
    do_reset();
    depth_cfg_i = 2'd1;
    hold = 1'b1;
    base = lg_n;
    try_req(0, acc);
    chk(acc, "R12", "first entry accepted", int'(acc), 1);
    chk(idle_o == 1'b0, "R13", "busy after accept", int'(idle_o), 0);
    try_req(0, acc);
    chk(!acc, "R12", "same bank refused", int'(acc), 0);
    try_req(1, acc);
    chk(acc, "R12", "second bank accepted", int'(acc), 1);
    try_req(2, acc);
    chk(!acc, "R12", "depth limit refuses", int'(acc), 0);
    depth_cfg_i = 2'd3;
    try_req(2, acc);
    chk(acc, "R12", "third bank accepted", int'(acc), 1);
    try_req(3, acc);
    chk(acc, "R12", "fourth bank accepted", int'(acc), 1);
    hold = 1'b0;
    wait_idle("R13");
    chk(lg_n - base == 8, "R12", "command count", lg_n - base, 8);
    for (int i = 0; i < 4; i++) begin
      chk_cmd(base + 2 * i, 1, i, i + 1, "R12");
      chk_cmd(base + 2 * i + 1, 2, i, i + 8, "R12");
    end
  endtask

  initial begin
    t_reset();
    t_closed_and_hit();
    t_miss();
    t_close_hint();
    t_refresh();
    t_gate();
    t_hold();
    t_queue();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule